// File: doc/BRIEF.md
# Paged Register Bridge over MDIO

This block is a management-bus slave that opens a 32-bit, byte-addressed internal register space to a host that can only issue ordinary 16-bit clause-22 management frames. It repurposes the 5-bit PHY address of each frame. The two upper bits pick what the frame does. The three lower bits, together with the 5-bit register field, form the low part of an internal byte address. A separate page register, loaded by its own frame type, supplies the high address bits. Each page is a 512-byte window of 4-byte-aligned 32-bit registers.

A 32-bit register moves as two 16-bit halves. The low half sits at the word address and the high half at word address + 2. A write of the low half is only staged. The internal write happens once, with the full word, when the high half arrives. A read of the low half fetches the whole word into a snapshot, and a later read of the high half is answered from that snapshot. Frames whose upper PHY address bits are zero are meant for real PHYs. The bridge leaves them alone and copies the clock and data pins to a downstream port.

MDC and MDIO are sampled by the system clock through a small synchronizer. MDC must therefore run well below the system clock: at least four system clocks per MDC half period.

Top module: `mdio_page_bridge`

## Requirements
- R1: The access mode comes from PHY address bits [4:3]. 2'b11 selects page load, 2'b10 selects register access and 2'b00 selects bypass. With 2'b01 the frame causes no drive, no internal access and no state change.
- R2: A write frame in page mode whose register field is 0 loads data bits [9:0] into the page register, and data bits [15:10] are ignored. A page-mode write with a nonzero register field has no effect.
- R3: In register mode the internal byte address is {page, PHY address[2:0], register field[4:1], 2'b00}. Register field bit 0 selects the half: 0 is bits [15:0] of the word and 1 is bits [31:16].
- R4: A low-half write only stages its data and causes no internal access. A high-half write issues exactly one single-cycle `rf_wr`, with `rf_wdata` = {high data, staged low data}.
- R5: A low-half read pulses `rf_rd` for one cycle, captures `rf_rdata` on the following cycle and returns its bits [15:0]. A high-half read returns bits [31:16] of that snapshot and pulses no `rf_rd`.
- R6: In a register-mode read, MDIO stays released through the first turnaround bit and is driven 0 in the second. The 16 data bits follow MSB first, each one presented after the MDC rising edge that ends the previous bit. MDIO is released after the last data bit.
- R7: A frame begins at the first 0 sampled on an MDC rising edge while idle. Its layout is start(2), opcode(2), PHY address(5), register field(5), turnaround(2), data(16). A start other than 01, or an opcode other than 10 (read) or 01 (write), gives no drive, no internal access and no state change.
- R8: A bypass-mode frame is never driven by the bridge and causes no internal access. `fwd_mdc` and `fwd_mdio` always copy `mdc` and `mdio_i`.
- R9: The page register cannot be read back: a read frame in page mode leaves MDIO undriven.
- R10: Reset returns the page register to PAGE_RST (default 0), releases MDIO and holds `rf_rd` and `rf_wr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data as seen on the bus |
| mdio_o | output | 1 | Management data driven by the bridge |
| mdio_oe | output | 1 | High while the bridge drives MDIO |
| fwd_mdc | output | 1 | Management clock copied to the downstream PHY port |
| fwd_mdio | output | 1 | Management data copied to the downstream PHY port |
| rf_addr | output | PAGE_W+9 | Internal byte address, word aligned |
| rf_rd | output | 1 | One-cycle internal read strobe |
| rf_rdata | input | 32 | Read data, valid on the cycle after `rf_rd` |
| rf_wr | output | 1 | One-cycle internal write strobe |
| rf_wdata | output | 32 | Full 32-bit write word |

## Verification
The checker watches several invariants on every cycle. Internal read and write strobes are single pulses and never coincide. Every turn-on of the MDIO driver starts with the turnaround zero. No internal write happens while the bridge drives the bus. Other properties only show up in the bench's frame scenarios. These are the address composition from page, PHY and register fields, the staging of the low half until the high half arrives, and high-half reads served from the snapshot without a new fetch. The silence on bypass, reserved-mode, page-read and malformed frames, and the page register's return to its reset value, are also bench-only.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_REG    = 2'b10,
        MODE_PAGE   = 2'b11
    } acc_mode_e;

    typedef struct packed {
        logic [1:0] st;
        logic [1:0] op;
        logic [4:0] phy;
        logic [4:0] regf;
    } hdr_t;

    localparam logic [1:0] ST_OK = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    // bit indices within a frame, counted from the first start bit
    localparam int HDR_LAST   = 13;
    localparam int TA_FIRST   = 14;
    localparam int FRAME_LAST = 31;

    function automatic logic hdr_ok(hdr_t h);
        return (h.st == ST_OK) && ((h.op == OP_RD) || (h.op == OP_WR));
    endfunction

    function automatic acc_mode_e hdr_mode(hdr_t h);
        return acc_mode_e'(h.phy[4:3]);
    endfunction

endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic bit_s
);
    logic [STAGES-1:0] mdc_q;
    logic [STAGES-1:0] dat_q;
    logic              mdc_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q    <= '1;
            dat_q    <= '1;
            mdc_prev <= 1'b1;
        end else begin
            mdc_q    <= {mdc_q[STAGES-2:0], mdc};
            dat_q    <= {dat_q[STAGES-2:0], mdio_i};
            mdc_prev <= mdc_q[STAGES-1];
        end
    end

    assign mdc_rise = mdc_q[STAGES-1] & ~mdc_prev;
    assign bit_s    = dat_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mdc_rise,
    input  logic        bit_in,
    input  logic [15:0] rd_word,
    output logic        hdr_stb,
    output hdr_t        hdr_q,
    output logic        dat_stb,
    output logic [15:0] dat_q,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [5:0] C_HDR  = 6'(HDR_LAST);
    localparam logic [5:0] C_TA0  = 6'(TA_FIRST);
    localparam logic [5:0] C_TA1  = 6'(TA_FIRST + 1);
    localparam logic [5:0] C_LAST = 6'(FRAME_LAST);

    logic        busy;
    logic [5:0]  cnt;
    logic [14:0] sh;
    logic [15:0] osh;
    logic        rd_act;

    assign rd_act = hdr_ok(hdr_q) && (hdr_q.op == OP_RD) && (hdr_mode(hdr_q) == MODE_REG);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            osh     <= '0;
            hdr_q   <= '0;
            hdr_stb <= 1'b0;
            dat_stb <= 1'b0;
            dat_q   <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            hdr_stb <= 1'b0;
            dat_stb <= 1'b0;
            if (mdc_rise) begin
                sh <= {sh[13:0], bit_in};
                if (!busy) begin
                    if (!bit_in) begin
                        busy <= 1'b1;
                        cnt  <= 6'd1;
                    end
                end else begin
                    cnt <= cnt + 6'd1;
                    if (cnt == C_HDR) begin
                        hdr_q   <= {sh[12:0], bit_in};
                        hdr_stb <= 1'b1;
                    end
                    if (cnt == C_TA0 && rd_act) begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b0;
                    end else if (cnt == C_TA1 && mdio_oe) begin
                        mdio_o <= rd_word[15];
                        osh    <= {rd_word[14:0], 1'b0};
                    end else if (cnt > C_TA1 && cnt < C_LAST && mdio_oe) begin
                        mdio_o <= osh[15];
                        osh    <= {osh[14:0], 1'b0};
                    end
                    if (cnt == C_LAST) begin
                        busy    <= 1'b0;
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                        dat_q   <= {sh, bit_in};
                        dat_stb <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mdio_reg_port.sv
module mdio_reg_port
    import mdio_bridge_pkg::*;
#(
    parameter int               PAGE_W   = 10,
    parameter logic [PAGE_W-1:0] PAGE_RST = '0,
    localparam int              ADDR_W   = PAGE_W + 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_stb,
    input  hdr_t              hdr,
    input  logic              dat_stb,
    input  logic [15:0]       dat,
    input  logic [31:0]       rf_rdata,
    output logic [15:0]       rd_word,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_rd,
    output logic              rf_wr,
    output logic [31:0]       rf_wdata
);
    logic [PAGE_W-1:0] page_q;
    logic [15:0]       stage_q;
    logic [31:0]       snap_q;
    logic              fetch_q;
    acc_mode_e         mode;
    logic              ok, half;
    logic [ADDR_W-1:0] word_addr;

    assign mode      = hdr_mode(hdr);
    assign ok        = hdr_ok(hdr);
    assign half      = hdr.regf[0];
    assign word_addr = {page_q, hdr.phy[2:0], hdr.regf[4:1], 2'b00};
    assign rd_word   = half ? snap_q[31:16] : snap_q[15:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q   <= PAGE_RST;
            stage_q  <= '0;
            snap_q   <= '0;
            fetch_q  <= 1'b0;
            rf_addr  <= '0;
            rf_rd    <= 1'b0;
            rf_wr    <= 1'b0;
            rf_wdata <= '0;
        end else begin
            rf_rd   <= 1'b0;
            rf_wr   <= 1'b0;
            fetch_q <= rf_rd;
            if (fetch_q)
                snap_q <= rf_rdata;
            if (hdr_stb && ok && hdr.op == OP_RD && mode == MODE_REG && !half) begin
                rf_rd   <= 1'b1;
                rf_addr <= word_addr;
            end
            if (dat_stb && ok && hdr.op == OP_WR) begin
                unique case (mode)
                    MODE_PAGE: if (hdr.regf == 5'd0) page_q <= dat[PAGE_W-1:0];
                    MODE_REG: begin
                        if (!half) begin
                            stage_q <= dat;
                        end else begin
                            rf_wr    <= 1'b1;
                            rf_addr  <= word_addr;
                            rf_wdata <= {dat, stage_q};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int               PAGE_W      = 10,
    parameter logic [PAGE_W-1:0] PAGE_RST    = '0,
    parameter int               SYNC_STAGES = 2,
    localparam int              ADDR_W      = PAGE_W + 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              fwd_mdc,
    output logic              fwd_mdio,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_rd,
    input  logic [31:0]       rf_rdata,
    output logic              rf_wr,
    output logic [31:0]       rf_wdata
);
    logic        mdc_rise, bit_s;
    logic        hdr_stb, dat_stb;
    hdr_t        hdr;
    logic [15:0] dat, rd_word;

    // R8: downstream PHYs see the bus unchanged
    assign fwd_mdc  = mdc;
    assign fwd_mdio = mdio_i;

    mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
        .mdc_rise(mdc_rise), .bit_s(bit_s)
    );

    mdio_frame_engine u_frame (
        .clk(clk), .rst(rst), .mdc_rise(mdc_rise), .bit_in(bit_s),
        .rd_word(rd_word), .hdr_stb(hdr_stb), .hdr_q(hdr),
        .dat_stb(dat_stb), .dat_q(dat), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    mdio_reg_port #(.PAGE_W(PAGE_W), .PAGE_RST(PAGE_RST)) u_port (
        .clk(clk), .rst(rst), .hdr_stb(hdr_stb), .hdr(hdr),
        .dat_stb(dat_stb), .dat(dat), .rf_rdata(rf_rdata),
        .rd_word(rd_word), .rf_addr(rf_addr), .rf_rd(rf_rd),
        .rf_wr(rf_wr), .rf_wdata(rf_wdata)
    );
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk (
    input logic clk,
    input logic rst,
    input logic mdio_o,
    input logic mdio_oe,
    input logic rf_rd,
    input logic rf_wr
);
    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rf_rd && rf_wr));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> !rf_wr);

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        rf_rd |=> !rf_rd);

    // R6
    ta_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_o);

    // R4
    no_wr_while_drive_chk: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> !rf_wr);
endmodule

bind mdio_page_bridge mdio_page_bridge_chk u_chk (
    .clk(clk), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rf_rd(rf_rd), .rf_wr(rf_wr)
);

// File: tb/mdio_page_bridge_test.sv
module mdio_page_bridge_test;
    localparam int HALF = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, mdc, m_en, m_val;
    logic        mdio_o, mdio_oe, fwd_mdc, fwd_mdio, rf_rd, rf_wr;
    logic [18:0] rf_addr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        mdio_line;

    assign mdio_line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

    function automatic logic [31:0] pat(input logic [18:0] a);
        return {a[15:0] ^ 16'hC3A5, a[18:3]};
    endfunction
    assign rf_rdata = pat(rf_addr);

    mdio_page_bridge uut (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_line),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .fwd_mdc(fwd_mdc), .fwd_mdio(fwd_mdio),
        .rf_addr(rf_addr), .rf_rd(rf_rd), .rf_rdata(rf_rdata),
        .rf_wr(rf_wr), .rf_wdata(rf_wdata)
    );

    typedef struct { logic [18:0] a; logic [31:0] d; } wr_t;
    wr_t exp_q[$];
    int n_chk = 0, n_fail = 0, wr_seen = 0, rd_seen = 0;
    logic [9:0] pg;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: R3 address and R4 commit word
    always @(negedge clk) begin
        wr_t e;
        if (!rst) begin
            if (rf_rd) rd_seen++;
            if (rf_wr) begin
                wr_seen++;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R4 unexpected write: actual %h expected none", rf_wdata);
                end else begin
                    e = exp_q.pop_front();
                    if (rf_addr !== e.a || rf_wdata !== e.d) begin
                        n_fail++;
                        $display("FAIL R3 write addr/data: actual %h/%h expected %h/%h",
                                 rf_addr, rf_wdata, e.a, e.d);
                    end
                end
            end
        end
    end

    task automatic frame(input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] regf,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output bit ta_ok, output bit drove);
        logic [31:0] bits;
        bit is_rd, early;
        bits  = {st, op, phy, regf, 2'b10, wd};
        is_rd = (op == 2'b10);
        rd = '0; ta_ok = 0; drove = 0; early = 0;
        for (int i = 0; i < 32; i++) begin
            mdc = 0; m_en = 1; m_val = 1;
            repeat (HALF) @(posedge clk); #1;
            mdc = 1;
            repeat (HALF) @(posedge clk); #1;
        end
        for (int k = 0; k < 32; k++) begin
            mdc = 0; m_en = !(is_rd && k >= 14); m_val = bits[31-k];
            repeat (HALF) @(posedge clk); #1;
            if (k <= 14 && mdio_oe) early = 1;
            if (k == 15) ta_ok = mdio_oe && !mdio_o && !early;
            if (k >= 16) rd[31-k] = mdio_o;
            if (mdio_oe) drove = 1;
            mdc = 1;
            repeat (HALF) @(posedge clk); #1;
        end
        m_en = 1; m_val = 1;
        for (int i = 0; i < 4; i++) begin
            mdc = 0; repeat (HALF) @(posedge clk); #1;
            if (mdio_oe) begin drove = 1; ta_ok = 0; end
            mdc = 1; repeat (HALF) @(posedge clk); #1;
        end
    endtask

    function automatic logic [18:0] xaddr(input logic [2:0] sub, input logic [3:0] w);
        return {pg, sub, w, 2'b00};
    endfunction

    task automatic reg_write(input logic [2:0] sub, input logic [3:0] w,
                             input logic [31:0] d, input string req);
        logic [15:0] r; bit t, dr; int w0; wr_t e;
        w0 = wr_seen;
        frame(2'b01, 2'b01, {2'b10, sub}, {w, 1'b0}, d[15:0], r, t, dr);
        repeat (4) @(posedge clk); #1;
        chk(wr_seen == w0, "R4", "no write after low half", wr_seen, w0);
        e.a = xaddr(sub, w); e.d = d;
        exp_q.push_back(e);
        frame(2'b01, 2'b01, {2'b10, sub}, {w, 1'b1}, d[31:16], r, t, dr);
        repeat (4) @(posedge clk); #1;
        chk(wr_seen == w0 + 1 && exp_q.size() == 0, req, "one commit after high half", wr_seen, w0 + 1);
        chk(!dr, "R6", "write frame not driven", dr, 0);
    endtask

    task automatic page_write(input logic [4:0] regf, input logic [15:0] d);
        logic [15:0] r; bit t, dr;
        frame(2'b01, 2'b01, 5'b11000, regf, d, r, t, dr);
        if (regf == 5'd0) pg = d[9:0];
    endtask

    initial begin
        logic [15:0] r; bit t, dr; int r0, w0;
        logic [31:0] p;
        rst = 1; mdc = 1; m_en = 1; m_val = 1; pg = '0;
        repeat (5) @(posedge clk); #1;
        chk(!mdio_oe && !rf_rd && !rf_wr, "R10", "idle outputs in reset", {mdio_oe, rf_rd, rf_wr}, 0);
        rst = 0;
        repeat (3) @(posedge clk); #1;

        // page load, upper data bits ignored
        page_write(5'd0, 16'hFD55);
        reg_write(3'b011, 4'b0110, 32'hABCD1234, "R2");

        // low-half read fetches, high-half read uses snapshot
        r0 = rd_seen;
        frame(2'b01, 2'b10, 5'b10101, 5'b10010, 16'h0, r, t, dr);
        p = pat(xaddr(3'b101, 4'b1001));
        chk(r == p[15:0], "R5", "low half read data", r, p[15:0]);
        chk(t, "R6", "turnaround released then zero", t, 1);
        chk(rd_seen == r0 + 1, "R5", "one fetch on low read", rd_seen, r0 + 1);
        frame(2'b01, 2'b10, 5'b10101, 5'b10011, 16'h0, r, t, dr);
        chk(r == p[31:16], "R5", "high half from snapshot", r, p[31:16]);
        chk(rd_seen == r0 + 1, "R5", "no fetch on high read", rd_seen, r0 + 1);
        chk(t, "R6", "turnaround on high read", t, 1);

        // second location, different sub-address
        frame(2'b01, 2'b10, 5'b10010, 5'b01110, 16'h0, r, t, dr);
        p = pat(xaddr(3'b010, 4'b0111));
        chk(r == p[15:0], "R3", "address from page/phy/reg", r, p[15:0]);

        // malformed frames: bad opcodes and bad start
        w0 = wr_seen; r0 = rd_seen;
        frame(2'b01, 2'b11, 5'b10011, 5'b01101, 16'h5555, r, t, dr);
        chk(!dr, "R7", "opcode 11 not driven", dr, 0);
        frame(2'b01, 2'b00, 5'b10011, 5'b01100, 16'h5555, r, t, dr);
        frame(2'b00, 2'b10, 5'b10011, 5'b01100, 16'h0, r, t, dr);
        chk(!dr, "R7", "bad start read not driven", dr, 0);
        frame(2'b00, 2'b01, 5'b10011, 5'b01101, 16'h7777, r, t, dr);
        chk(wr_seen == w0 && rd_seen == r0, "R7", "no access on malformed frames", wr_seen, w0);

        // bypass frames
        frame(2'b01, 2'b10, 5'b00010, 5'b00100, 16'h0, r, t, dr);
        chk(!dr, "R8", "bypass read not driven", dr, 0);
        frame(2'b01, 2'b01, 5'b00111, 5'b00101, 16'h1111, r, t, dr);
        chk(wr_seen == w0 && rd_seen == r0, "R8", "no access on bypass", rd_seen, r0);
        mdc = 0; m_val = 0; #3;
        chk(fwd_mdc == 0 && fwd_mdio == 0, "R8", "forwarded pins low", {fwd_mdc, fwd_mdio}, 0);
        mdc = 1; m_val = 1; #3;
        chk(fwd_mdc == 1 && fwd_mdio == 1, "R8", "forwarded pins high", {fwd_mdc, fwd_mdio}, 2'b11);

        // reserved mode 01
        frame(2'b01, 2'b01, 5'b01001, 5'b00011, 16'h2222, r, t, dr);
        frame(2'b01, 2'b10, 5'b01001, 5'b00010, 16'h0, r, t, dr);
        chk(!dr && wr_seen == w0 && rd_seen == r0, "R1", "reserved mode inert", dr, 0);

        // page read not returned
        frame(2'b01, 2'b10, 5'b11000, 5'b00000, 16'h0, r, t, dr);
        chk(!dr, "R9", "page read not driven", dr, 0);

        // page write with nonzero register field ignored
        page_write(5'b00001, 16'h03FF);
        reg_write(3'b001, 4'b0010, 32'h0BAD_F00D, "R2");

        // full page value
        page_write(5'd0, 16'hFFFF);
        reg_write(3'b111, 4'b1111, 32'hFFFF_0001, "R3");

        // reset restores page
        rst = 1; repeat (3) @(posedge clk); #1;
        chk(!mdio_oe && !rf_wr && !rf_rd, "R10", "idle after reset", mdio_oe, 0);
        rst = 0; pg = '0; repeat (3) @(posedge clk); #1;
        reg_write(3'b100, 4'b0001, 32'h1357_9BDF, "R10");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule